// File: doc/BRIEF.md
# Byte Memory DMA Controller

This controller copies whole words between an 8-bit-wide external byte memory and the on-chip program or data RAM. Software sets up an internal word address, an external page and byte offset, a word format, a direction and a word count. Writing a non-zero count starts the move. Each word is built from, or split into, one to three byte accesses, most significant byte first. Each word then takes exactly one stolen cycle on the internal RAM port.

The external bus is shared with the core. Whenever the core asks for the external bus, the controller holds back its own byte access. A context-reset option keeps the core stopped for the whole transfer and then restarts it at address 0. After a reset with byte booting selected, the controller starts a 32-word program load on its own. The external memory, the internal RAM and the core are modelled outside the block with simple request/acknowledge pins.

Top module: `bdma_ctrl`

## Requirements
- R1: The external byte address is 22 bits wide: an 8-bit page in bits 21:14 above a 14-bit offset in bits 13:0. It increments by one after every accepted byte access, and an offset of 0x3FFF carries into the page. Register 2 reads back the live offset. Register 1 reads back the live page in bits 11:4.
- R2: With direction 0 (byte memory to internal), bytes are read most significant first. The 2-bit format selects how they are placed. Format 0 packs 3 bytes into bits 23:16, 15:8 and 7:0 of a program word. Format 1 packs 2 bytes into bits 15:8 and 7:0 of a data word. Format 2 places 1 byte in bits 15:8. Format 3 places 1 byte in bits 7:0. Every bit not written is 0.
- R3: With direction 1 (internal to byte memory), each word is read from internal RAM first. Its bytes are then written to byte memory in the lane order listed in R2.
- R4: A write of a non-zero value to the count register (register 3) starts a transfer. A write of zero does not. The count reads back live and drops by exactly one per finished word. When it reaches 0, the transfer ends and `done_irq` pulses high for one cycle.
- R5: Each word uses exactly one internal RAM access, with `int_addr` counting up from the start address. `int_pm` is 1 for format 0 and 0 for the other formats.
- R6: The controller never drives `ext_req` in a cycle where `core_ext_req` is high. Held-back accesses still finish later with correct data.
- R7: When the context-reset bit (control bit 3) is 1, `core_halt` is high for the whole transfer, and `core_restart` pulses together with `done_irq`. When the bit is 0, `core_halt` stays low and `core_restart` never pulses.
- R8: A reset with `boot_mode` = 1 gives the following state: page, offset, internal address and direction are 0; the format is 0; the count is 32; and the context-reset bit is 1. The transfer is already busy and `core_halt` is high. The controller then loads 32 program words from byte addresses 0 to 95 into internal addresses 0 to 31.
- R9: While a transfer is active, every register write is ignored. Control register bit 15 reads 1 while a transfer is active and 0 otherwise.
- R10: A reset with `boot_mode` = 0 leaves the controller idle with a count of 0, a busy bit of 0 and `core_halt` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_mode | input | 1 | Selects the boot defaults at reset |
| reg_we | input | 1 | Register write strobe |
| reg_wsel | input | 2 | Write select: 0 internal address, 1 control, 2 offset, 3 count |
| reg_wdata | input | 16 | Register write data |
| reg_rsel | input | 2 | Read select, same map as the write select |
| reg_rdata | output | 16 | Read data; in the control register, bit 15 is busy |
| core_ext_req | input | 1 | Core is using the external bus; this has priority |
| ext_req | output | 1 | Byte access request |
| ext_we | output | 1 | Byte access is a write |
| ext_addr | output | 22 | Byte address |
| ext_wdata | output | 8 | Byte write data |
| ext_rdata | input | 8 | Byte read data, valid with ext_ack |
| ext_ack | input | 1 | Byte access accepted this cycle |
| int_req | output | 1 | Internal RAM cycle request |
| int_we | output | 1 | Internal access is a write |
| int_pm | output | 1 | 1 = program RAM, 0 = data RAM |
| int_addr | output | 14 | Internal word address |
| int_wdata | output | 24 | Internal write word |
| int_rdata | input | 24 | Internal read word, valid with int_gnt |
| int_gnt | input | 1 | Internal cycle granted this cycle |
| core_halt | output | 1 | Holds the core stopped |
| core_restart | output | 1 | Pulse: restart the core at address 0 |
| done_irq | output | 1 | Pulse at the end of a transfer |

## Verification
Some rules are checked on every cycle. The core always wins the external bus. Byte and internal requests never overlap. The byte address steps by one, with page carry, after each accepted byte. `done_irq` is a single pulse that comes with busy low. `core_halt` is high only while busy, and `core_restart` appears only with `done_irq`. Other behaviour needs the bench scenarios: the byte-lane placement and zero fill of each format, the store byte order, the live count decrement, the ignored writes while busy, and the boot load contents. The bench sweeps every format in both directions across a page boundary, with the core and both memories stalling in fixed patterns.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
  localparam int WORD_W = 24;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    FMT_PM24 = 2'd0,
    FMT_DM16 = 2'd1,
    FMT_DMHI = 2'd2,
    FMT_DMLO = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_IRD  = 2'd1,
    ST_EXT  = 2'd2,
    ST_IWR  = 2'd3
  } st_e;

  function automatic logic [1:0] bytes_per_word(fmt_e f);
    case (f)
      FMT_PM24: return 2'd3;
      FMT_DM16: return 2'd2;
      default:  return 2'd1;
    endcase
  endfunction

  // lane 2 = bits 23:16, lane 1 = bits 15:8, lane 0 = bits 7:0
  function automatic logic [1:0] lane_of(fmt_e f, logic [1:0] idx);
    case (f)
      FMT_PM24: return 2'd2 - idx;
      FMT_DM16: return 2'd1 - idx;
      FMT_DMHI: return 2'd1;
      default:  return 2'd0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] put_byte(logic [WORD_W-1:0] w, fmt_e f,
                                                 logic [1:0] idx, logic [BYTE_W-1:0] b);
    logic [WORD_W-1:0] r;
    r = w;
    case (lane_of(f, idx))
      2'd2:    r[23:16] = b;
      2'd1:    r[15:8]  = b;
      default: r[7:0]   = b;
    endcase
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] get_byte(logic [WORD_W-1:0] w, fmt_e f,
                                                 logic [1:0] idx);
    case (lane_of(f, idx))
      2'd2:    return w[23:16];
      2'd1:    return w[15:8];
      default: return w[7:0];
    endcase
  endfunction
endpackage

// File: rtl/bdma_regs.sv
module bdma_regs
  import bdma_pkg::*;
#(
  parameter int INT_AW     = 14,
  parameter int PAGE_W     = 8,
  parameter int OFF_W      = 14,
  parameter int CNT_W      = 14,
  parameter int BOOT_WORDS = 32,
  localparam int EXT_AW    = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_mode,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [15:0]       wr_data,
  input  logic [1:0]        rd_sel,
  output logic [15:0]       rd_data,
  input  logic              ext_step,
  input  logic              int_step,
  input  logic              cnt_step,
  output logic [INT_AW-1:0] int_addr,
  output logic [EXT_AW-1:0] ext_addr,
  output fmt_e              fmt,
  output logic              dir,
  output logic              ctx,
  output logic              busy,
  output logic              last_word,
  output logic              done_pulse,
  output logic              restart_pulse
);
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wr_ok;
  logic [CNT_W-1:0]  cnt_wr;

  assign wr_ok     = wr_en && !busy;
  assign cnt_wr    = wr_data[CNT_W-1:0];
  assign ext_addr  = {page_q, off_q};
  assign last_word = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q        <= '0;
      off_q         <= '0;
      int_addr      <= '0;
      fmt           <= FMT_PM24;
      dir           <= 1'b0;
      ctx           <= boot_mode;
      cnt_q         <= boot_mode ? CNT_W'(BOOT_WORDS) : '0;
      busy          <= boot_mode;
      done_pulse    <= 1'b0;
      restart_pulse <= 1'b0;
    end else begin
      done_pulse    <= 1'b0;
      restart_pulse <= 1'b0;
      if (wr_ok) begin
        case (wr_sel)
          2'd0: int_addr <= wr_data[INT_AW-1:0];
          2'd1: begin
            fmt    <= fmt_e'(wr_data[1:0]);
            dir    <= wr_data[2];
            ctx    <= wr_data[3];
            page_q <= wr_data[4 +: PAGE_W];
          end
          2'd2: off_q <= wr_data[OFF_W-1:0];
          default: begin
            if (cnt_wr != '0) begin
              cnt_q <= cnt_wr;
              busy  <= 1'b1;
            end
          end
        endcase
      end
      if (ext_step) {page_q, off_q} <= {page_q, off_q} + EXT_AW'(1);
      if (int_step) int_addr <= int_addr + INT_AW'(1);
      if (cnt_step) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (last_word) begin
          busy          <= 1'b0;
          done_pulse    <= 1'b1;
          restart_pulse <= ctx;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      2'd0: rd_data[INT_AW-1:0] = int_addr;
      2'd1: begin
        rd_data[1:0]          = fmt;
        rd_data[2]            = dir;
        rd_data[3]            = ctx;
        rd_data[4 +: PAGE_W]  = page_q;
        rd_data[15]           = busy;
      end
      2'd2: rd_data[OFF_W-1:0] = off_q;
      default: rd_data[CNT_W-1:0] = cnt_q;
    endcase
  end
endmodule

// File: rtl/bdma_wordbuf.sv
module bdma_wordbuf
  import bdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  fmt_e              fmt,
  input  logic              clr,
  input  logic              ld_word,
  input  logic [WORD_W-1:0] word_in,
  input  logic              put,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              adv,
  output logic [WORD_W-1:0] word,
  output logic [BYTE_W-1:0] cur_byte,
  output logic              last_byte
);
  logic [1:0] idx;

  assign cur_byte  = get_byte(word, fmt, idx);
  assign last_byte = (idx == bytes_per_word(fmt) - 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      word <= '0;
      idx  <= '0;
    end else if (ld_word) begin
      word <= word_in;
      idx  <= '0;
    end else begin
      if (put) word <= put_byte(word, fmt, idx, byte_in);
      if (adv) idx <= idx + 2'd1;
    end
  end
endmodule

// File: rtl/bdma_engine.sv
module bdma_engine
  import bdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              last_word,
  input  fmt_e              fmt,
  input  logic              dir,
  input  logic              core_ext_req,
  input  logic              ext_ack,
  input  logic [BYTE_W-1:0] ext_rdata,
  input  logic              int_gnt,
  input  logic [WORD_W-1:0] int_rdata,
  output logic              ext_req,
  output logic              ext_we,
  output logic [BYTE_W-1:0] ext_wdata,
  output logic              int_req,
  output logic              int_we,
  output logic [WORD_W-1:0] int_wdata,
  output logic              ext_step,
  output logic              int_step,
  output logic              cnt_step
);
  st_e  st, nxt;
  logic clr, ld_word, put, adv, last_byte;

  bdma_wordbuf u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt      (fmt),
    .clr      (clr),
    .ld_word  (ld_word),
    .word_in  (int_rdata),
    .put      (put),
    .byte_in  (ext_rdata),
    .adv      (adv),
    .word     (int_wdata),
    .cur_byte (ext_wdata),
    .last_byte(last_byte)
  );

  always_comb begin
    nxt      = st;
    clr      = 1'b0;
    ld_word  = 1'b0;
    put      = 1'b0;
    adv      = 1'b0;
    ext_req  = 1'b0;
    ext_we   = 1'b0;
    int_req  = 1'b0;
    int_we   = 1'b0;
    ext_step = 1'b0;
    int_step = 1'b0;
    cnt_step = 1'b0;
    case (st)
      ST_IDLE: begin
        clr = 1'b1;
        if (busy) nxt = dir ? ST_IRD : ST_EXT;
      end
      ST_IRD: begin
        int_req = 1'b1;
        if (int_gnt) begin
          int_step = 1'b1;
          ld_word  = 1'b1;
          nxt      = ST_EXT;
        end
      end
      ST_EXT: begin
        ext_req = !core_ext_req;
        ext_we  = dir;
        if (ext_req && ext_ack) begin
          ext_step = 1'b1;
          put      = !dir;
          adv      = 1'b1;
          if (last_byte) begin
            if (dir) begin
              cnt_step = 1'b1;
              nxt      = last_word ? ST_IDLE : ST_IRD;
            end else begin
              nxt = ST_IWR;
            end
          end
        end
      end
      default: begin
        int_req = 1'b1;
        int_we  = 1'b1;
        if (int_gnt) begin
          int_step = 1'b1;
          cnt_step = 1'b1;
          clr      = 1'b1;
          nxt      = last_word ? ST_IDLE : ST_EXT;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end
endmodule

// File: rtl/bdma_ctrl.sv
module bdma_ctrl
  import bdma_pkg::*;
#(
  parameter int INT_AW     = 14,
  parameter int PAGE_W     = 8,
  parameter int OFF_W      = 14,
  parameter int CNT_W      = 14,
  parameter int BOOT_WORDS = 32,
  localparam int EXT_AW    = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_mode,
  input  logic              reg_we,
  input  logic [1:0]        reg_wsel,
  input  logic [15:0]       reg_wdata,
  input  logic [1:0]        reg_rsel,
  output logic [15:0]       reg_rdata,
  input  logic              core_ext_req,
  output logic              ext_req,
  output logic              ext_we,
  output logic [EXT_AW-1:0] ext_addr,
  output logic [7:0]        ext_wdata,
  input  logic [7:0]        ext_rdata,
  input  logic              ext_ack,
  output logic              int_req,
  output logic              int_we,
  output logic              int_pm,
  output logic [INT_AW-1:0] int_addr,
  output logic [23:0]       int_wdata,
  input  logic [23:0]       int_rdata,
  input  logic              int_gnt,
  output logic              core_halt,
  output logic              core_restart,
  output logic              done_irq
);
  fmt_e fmt;
  logic dir, ctx, busy, last_word;
  logic ext_step, int_step, cnt_step;

  bdma_regs #(
    .INT_AW(INT_AW), .PAGE_W(PAGE_W), .OFF_W(OFF_W),
    .CNT_W(CNT_W), .BOOT_WORDS(BOOT_WORDS)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .boot_mode    (boot_mode),
    .wr_en        (reg_we),
    .wr_sel       (reg_wsel),
    .wr_data      (reg_wdata),
    .rd_sel       (reg_rsel),
    .rd_data      (reg_rdata),
    .ext_step     (ext_step),
    .int_step     (int_step),
    .cnt_step     (cnt_step),
    .int_addr     (int_addr),
    .ext_addr     (ext_addr),
    .fmt          (fmt),
    .dir          (dir),
    .ctx          (ctx),
    .busy         (busy),
    .last_word    (last_word),
    .done_pulse   (done_irq),
    .restart_pulse(core_restart)
  );

  bdma_engine u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .last_word   (last_word),
    .fmt         (fmt),
    .dir         (dir),
    .core_ext_req(core_ext_req),
    .ext_ack     (ext_ack),
    .ext_rdata   (ext_rdata),
    .int_gnt     (int_gnt),
    .int_rdata   (int_rdata),
    .ext_req     (ext_req),
    .ext_we      (ext_we),
    .ext_wdata   (ext_wdata),
    .int_req     (int_req),
    .int_we      (int_we),
    .int_wdata   (int_wdata),
    .ext_step    (ext_step),
    .int_step    (int_step),
    .cnt_step    (cnt_step)
  );

  assign int_pm    = (fmt == FMT_PM24);
  assign core_halt = busy && ctx;
endmodule

// File: rtl/bdma_ctrl_chk.sv
module bdma_ctrl_chk #(
  parameter int EXT_AW = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_ext_req,
  input logic              ext_req,
  input logic              ext_ack,
  input logic [EXT_AW-1:0] ext_addr,
  input logic              int_req,
  input logic              busy,
  input logic              done_irq,
  input logic              core_restart,
  input logic              core_halt
);
  AST_CORE_WINS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    core_ext_req |-> !ext_req); // R6

  AST_ONE_PORT_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_req && ext_req)); // R5

  AST_ADDR_STEP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && ext_ack) |=> (ext_addr == $past(ext_addr) + 1'b1)); // R1

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq); // R4

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !busy); // R4

  AST_HALT_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    core_halt |-> busy); // R7

  AST_RESTART_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    core_restart |-> done_irq); // R7
endmodule

bind bdma_ctrl bdma_ctrl_chk #(.EXT_AW(EXT_AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .core_ext_req(core_ext_req),
  .ext_req     (ext_req),
  .ext_ack     (ext_ack),
  .ext_addr    (ext_addr),
  .int_req     (int_req),
  .busy        (busy),
  .done_irq    (done_irq),
  .core_restart(core_restart),
  .core_halt   (core_halt)
);

// File: tb/bdma_ctrl_tb.sv
`timescale 1ns/1ps
module bdma_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_mode = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_wsel = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [1:0]  reg_rsel = 2'd1;
  logic [15:0] reg_rdata;
  logic        core_ext_req = 1'b0;
  logic        ext_req, ext_we;
  logic [21:0] ext_addr;
  logic [7:0]  ext_wdata, ext_rdata;
  logic        ext_ack;
  logic        int_req, int_we, int_pm;
  logic [13:0] int_addr;
  logic [23:0] int_wdata, int_rdata;
  logic        int_gnt;
  logic        core_halt, core_restart, done_irq;

  always #2 clk = ~clk;

  bdma_ctrl u_dut (.*);

  // memory models
  logic ext_ok = 1'b1, int_ok = 1'b1, stall_en = 1'b0;
  function automatic logic [7:0] ext_byte(logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ a[21:14];
  endfunction
  function automatic logic [23:0] int_word(logic [13:0] a);
    return {a[7:0] ^ 8'h3C, a[7:0] + 8'h51, ~a[7:0]};
  endfunction
  assign ext_ack   = ext_req && ext_ok;
  assign ext_rdata = ext_byte(ext_addr);
  assign int_gnt   = int_req && int_ok;
  assign int_rdata = int_word(int_addr);

  int cyc = 0;
  always @(posedge clk) begin
    cyc = cyc + 1;
    #1;
    core_ext_req = stall_en && (cyc % 3 == 0);
    ext_ok       = !stall_en || (cyc % 5 != 2);
    int_ok       = !stall_en || (cyc % 4 != 1);
  end

  int errors = 0, checks = 0;
  logic [21:0] el_a [256];
  logic [7:0]  el_d [256];
  logic        el_w [256];
  logic [13:0] il_a [64];
  logic [23:0] il_d [64];
  logic        il_pm [64];
  logic        il_w [64];
  int ne = 0, ni = 0, ndone = 0, nrst = 0, prio_bad = 0;
  int cchg = 0, cbad = 0;
  bit halt_seen = 0, trk = 0;
  logic [15:0] cprev;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ext_req && ext_ack && ne < 256) begin
        el_a[ne] = ext_addr; el_w[ne] = ext_we;
        el_d[ne] = ext_we ? ext_wdata : ext_rdata;
        ne = ne + 1;
      end
      if (int_req && int_gnt && ni < 64) begin
        il_a[ni] = int_addr; il_d[ni] = int_wdata; il_pm[ni] = int_pm; il_w[ni] = int_we;
        ni = ni + 1;
      end
      if (core_ext_req && ext_req) prio_bad = prio_bad + 1;
      if (done_irq) ndone = ndone + 1;
      if (core_restart) nrst = nrst + 1;
      if (core_halt) halt_seen = 1;
      if (trk && reg_rsel == 2'd3 && reg_rdata != cprev) begin
        if (reg_rdata != cprev - 16'd1) cbad = cbad + 1;
        cchg = cchg + 1;
        cprev = reg_rdata;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    ne = 0; ni = 0; ndone = 0; nrst = 0; prio_bad = 0;
    cchg = 0; cbad = 0; halt_seen = 0; trk = 0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_wsel = sel; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] d);
    reg_rsel = sel;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (ndone == 0 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    chk(ndone != 0, req, 0, 1);
    @(negedge clk);
  endtask

  function automatic int nbytes(int f);
    return (f == 0) ? 3 : (f == 1) ? 2 : 1;
  endfunction
  // bit position of the k-th byte sent/received within the word
  function automatic int shift_of(int f, int k);
    if (f == 0) return 16 - 8 * k;
    if (f == 1) return 8 - 8 * k;
    if (f == 2) return 8;
    return 0;
  endfunction

  task automatic finish_all();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    errors = errors + 1; checks = checks + 1;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    finish_all();
  end

  task automatic run(input int f, input int dir, input int ctx, input int pg,
                     input int off, input int ia, input int cnt);
    logic [15:0] v;
    int nb, start, fin, ext_ok_cnt, int_ok_cnt;
    nb = nbytes(f);
    wr(2'd0, 16'(ia));
    wr(2'd1, 16'(f | (dir << 2) | (ctx << 3) | (pg << 4)));
    wr(2'd2, 16'(off));
    clear_logs();
    reg_rsel = 2'd1;
    wr(2'd3, 16'(cnt));
    @(negedge clk);
    chk(reg_rdata[15] == 1'b1, "R9 busy bit set", reg_rdata[15], 1);
    reg_rsel = 2'd3;
    cprev = 16'(cnt); trk = 1;
    // these writes arrive while busy and must be ignored
    wr(2'd2, 16'h1111);
    wr(2'd1, 16'(((f ^ 1) | ((dir ^ 1) << 2) | (((pg ^ 8'hFF) & 8'hFF) << 4))));
    wr(2'd3, 16'd7);
    wait_done("R4 transfer ends");
    trk = 0;
    chk(cchg == cnt && cbad == 0, "R4 live count decrement", cchg, cnt);
    chk(ndone == 1, "R4 single done pulse", ndone, 1);
    chk(ni == cnt, "R5 one internal cycle per word", ni, cnt);
    chk(ne == cnt * nb, "R9 byte total unchanged by busy writes", ne, cnt * nb);
    chk(prio_bad == 0, "R6 core priority", prio_bad, 0);
    start = pg * 16384 + off;
    ext_ok_cnt = 0;
    for (int j = 0; j < ne; j++) begin
      logic [21:0] ea;
      logic [23:0] iw;
      logic [7:0]  eb;
      ea = 22'(start + j);
      iw = int_word(14'(ia + j / nb));
      eb = dir ? 8'(iw >> shift_of(f, j % nb)) : ext_byte(ea);
      if (el_a[j] == ea && el_w[j] == 1'(dir) && el_d[j] == eb) ext_ok_cnt++;
      else $display("FAIL %s byte %0d actual=%0h/%0h expected=%0h/%0h",
                    dir ? "R3" : "R1", j, el_a[j], el_d[j], ea, eb);
    end
    chk(ext_ok_cnt == ne, dir ? "R3 store bytes" : "R1 load addresses", ext_ok_cnt, ne);
    int_ok_cnt = 0;
    for (int w = 0; w < ni; w++) begin
      logic [23:0] exp_w;
      exp_w = 24'd0;
      for (int k = 0; k < nb; k++)
        exp_w = exp_w | (24'(ext_byte(22'(start + w * nb + k))) << shift_of(f, k));
      if (il_a[w] == 14'(ia + w) && il_pm[w] == (f == 0) && il_w[w] == (dir == 0) &&
          (dir == 1 || il_d[w] == exp_w)) int_ok_cnt++;
      else $display("FAIL R2 word %0d actual=%0h@%0h expected=%0h@%0h",
                    w, il_d[w], il_a[w], exp_w, 14'(ia + w));
    end
    chk(int_ok_cnt == ni, "R2 R5 word contents and address", int_ok_cnt, ni);
    if (ctx) chk(halt_seen && nrst == 1, "R7 halt and restart", nrst, 1);
    else     chk(!halt_seen && nrst == 0, "R7 core keeps running", {halt_seen, 8'(nrst)}, 0);
    chk(core_halt == 1'b0, "R7 halt released", core_halt, 0);
    fin = start + cnt * nb;
    rd(2'd2, v);
    chk(v == 16'(fin & 16'h3FFF), "R1 R9 offset after carry", v, fin & 16'h3FFF);
    rd(2'd1, v);
    chk(v[11:4] == 8'(fin >> 14) && v[15] == 1'b0 && v[1:0] == 2'(f),
        "R1 R9 page and busy", v, {8'(fin >> 14), 4'(f)});
    rd(2'd3, v);
    chk(v == 16'd0, "R4 count zero", v, 0);
  endtask

  initial begin
    logic [15:0] v;
    int good;
    // boot reset
    boot_mode = 1'b1; rst_n = 1'b0;
    clear_logs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    reg_rsel = 2'd3;
    @(negedge clk);
    chk(reg_rdata == 16'd32, "R8 boot count", reg_rdata, 32);
    reg_rsel = 2'd1;
    @(negedge clk);
    chk(reg_rdata == 16'h8008, "R8 boot control", reg_rdata, 16'h8008);
    chk(core_halt == 1'b1, "R8 core held", core_halt, 1);
    @(posedge clk); #1 rst_n = 1'b1;
    wait_done("R8 boot ends");
    chk(ni == 32 && ne == 96, "R8 boot sizes", ni, 32);
    good = 0;
    for (int w = 0; w < 32; w++) begin
      logic [23:0] e;
      e = {ext_byte(22'(3 * w)), ext_byte(22'(3 * w + 1)), ext_byte(22'(3 * w + 2))};
      if (il_a[w] == 14'(w) && il_pm[w] && il_w[w] && il_d[w] == e) good++;
      else $display("FAIL R8 word %0d actual=%0h expected=%0h", w, il_d[w], e);
    end
    chk(good == 32, "R8 boot words", good, 32);
    chk(nrst == 1 && halt_seen, "R8 R7 boot restart", nrst, 1);
    chk(core_halt == 1'b0, "R8 halt released", core_halt, 0);

    // plain reset
    @(posedge clk); #1;
    boot_mode = 1'b0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(2'd3, v);
    chk(v == 16'd0, "R10 count idle", v, 0);
    rd(2'd1, v);
    chk(v[15] == 1'b0 && core_halt == 1'b0, "R10 idle", v, 0);
    clear_logs();
    wr(2'd3, 16'd0);
    repeat (10) @(negedge clk);
    chk(ne == 0 && ni == 0 && reg_rdata[15] == 1'b0, "R4 zero count no start", ne + ni, 0);

    // sweep every format and direction across a page boundary
    for (int s = 0; s < 2; s++) begin
      stall_en = (s == 1);
      for (int f = 0; f < 4; f++)
        for (int d = 0; d < 2; d++)
          run(f, d, (f == 2 && d == 1) || (s == 1 && f == 0 && d == 0) ? 1 : 0,
              (f * 37 + d * 5 + s * 100) & 8'hFF, 14'h3FFF - (f + 2 * s), 10 * f + 5 * d, 4 + f);
    end
    // top page wraps the whole address space
    run(1, 0, 0, 8'hFF, 14'h3FFD, 3, 3);
    finish_all();
  end
endmodule